// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block makes a square-wave bit clock from a 16-bit time constant. A down-counter runs on a chosen source: either the processor clock or the rising edges of an external clock pin. Each time the counter reaches zero it reloads the time constant and the output toggles. One half-period of the output is therefore TC + 2 source ticks, and the output rate is the source rate divided by 2·(TC + 2). Software picks the constant for a wanted rate `bps` from a source rate `f` as floor((f + bps) / (2·bps)) − 2.

Software writes the time constant one byte at a time and can read both bytes back. A write made while the generator runs is held in the byte registers. The counter picks it up at its next reload, so the half-period in progress keeps its length. Each zero crossing sets a sticky zero-count status bit. It also produces a one-cycle interrupt pulse when the interrupt enable is set. A post-divider turns the bit clock into a sampling clock at the bit rate divided by 1, 16, 32 or 64.

All control and status pins are plain levels or pulses. There is no data stream, so the block has no valid/ready handshake.

Top module: `brg_top`

## Requirements
- R1: The time constant is written one byte per write: `tc_addr` = 0 selects bits 7:0 and `tc_addr` = 1 selects bits 15:8. `tc_rd_data` returns the byte selected by `tc_rd_addr`. Both bytes reset to 0.
- R2: With `src_pclk` = 1 and `brg_enable` = 1, `baud_clk` holds each level for exactly TC + 2 clock cycles, giving a 50 % duty cycle. After reset, the first rising edge of `baud_clk` comes on the (TC + 2)-th enabled clock edge.
- R3: For a source of f ticks per second, TC = floor((f + bps) / (2·bps)) − 2 gives a `baud_clk` period of 2·(TC + 2) ticks. This matches f / bps when f / bps is an even integer.
- R4: While `brg_enable` = 0, `baud_clk` is low on the cycle after the enable falls, and the countdown holds its value. After the enable is raised again, the count resumes where it stopped.
- R5: A time-constant write made while the generator runs does not change the half-period in progress. It takes effect from the next reload.
- R6: With `src_pclk` = 0, the counter advances once per rising edge of `ext_clk` after a two-flop synchronizer. With the pin static the output does not move. With `src_pclk` = 1, toggling `ext_clk` has no effect on the rate.
- R7: `zc_status` is set by every zero crossing and stays set until a `zc_ack` cycle clears it. If a crossing and an acknowledge fall in the same cycle, the bit stays set.
- R8: `zc_irq` is a one-cycle pulse, raised in the same cycle that `baud_clk` changes level, for every zero crossing while `zc_irq_en` = 1. It is never raised while `zc_irq_en` = 0.
- R9: `samp_div` selects the post-divider: 00 = ×1, 01 = ×16, 10 = ×32, 11 = ×64. The `samp_clk` period is that ratio times the `baud_clk` period, and ×1 makes `samp_clk` equal `baud_clk`.
- R10: While `brg_enable` = 0, `samp_clk` is low and the post-divider count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_wr_en | input | 1 | Write strobe for one time-constant byte |
| tc_addr | input | 1 | Byte select for writes (0 low, 1 high) |
| tc_wr_data | input | 8 | Byte written |
| tc_rd_addr | input | 1 | Byte select for read-back |
| tc_rd_data | output | 8 | Selected time-constant byte |
| brg_enable | input | 1 | Runs the countdown when high |
| src_pclk | input | 1 | 1 = count processor clock, 0 = count ext_clk edges |
| ext_clk | input | 1 | Asynchronous external clock pin |
| samp_div | input | 2 | Post-divider ratio code |
| zc_irq_en | input | 1 | Zero-count interrupt enable |
| zc_ack | input | 1 | Clears the zero-count status bit |
| baud_clk | output | 1 | Square-wave bit clock |
| samp_clk | output | 1 | Post-divided sampling clock |
| zc_status | output | 1 | Sticky zero-count status |
| zc_irq | output | 1 | One-cycle zero-count interrupt pulse |

## Verification
The hardest case to reach from the ports is a pause in the middle of a countdown. The bench has to stop the counter at a known count and later resume from that count. The stimulus starts from reset, where the first reload is pending, and enables for exactly five clock edges before dropping the enable for twenty cycles. It then counts the edges until the first rise: it must be the twelfth enabled edge overall for TC = 10. A second hard case is a write that lands on the reload edge itself. The bench issues the write on the half-cycle right after it sees a rising output, so the write and the reload share a clock edge, and it checks that the old constant still sets the length of that half-period.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    DIV_X1  = 2'b00,
    DIV_X16 = 2'b01,
    DIV_X32 = 2'b10,
    DIV_X64 = 2'b11
  } samp_div_e;

  function automatic int unsigned div_ratio(input samp_div_e code);
    case (code)
      DIV_X16: return 16;
      DIV_X32: return 32;
      DIV_X64: return 64;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/brg_tc_regs.sv
module brg_tc_regs #(
  parameter int TC_W   = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = TC_W / BYTE_W,
  localparam int AW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TC_W-1:0]   tc
);

  logic [BYTE_W-1:0] bytes_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[g] <= '0;
      end else if (wr_en && int'(wr_addr) == g) begin
        bytes_q[g] <= wr_data;
      end
    end
    assign tc[g*BYTE_W +: BYTE_W] = bytes_q[g];

    // R1: a write to this byte lands in the constant on the next edge
    p_byte_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == g) |=> (tc[g*BYTE_W +: BYTE_W] == $past(wr_data)));
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NB) rd_data = bytes_q[rd_addr];
  end

endmodule

// File: rtl/brg_src_tick.sv
module brg_src_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_pclk,
  input  logic ext_pin,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    if (src_pclk) tick = 1'b1;
    else          tick = sync_q[SYNC_STAGES-1] & ~last_q;
  end

  // R6: with the pin source, two ticks never come back to back
  p_ext_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pclk && tick) |=> !(tick && !src_pclk));

endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic [TC_W-1:0] tc,
  output logic            baud,
  output logic            zero_evt
);

  logic [TC_W-1:0] cnt_q;
  logic            reload_q;
  logic            baud_q;

  assign zero_evt = en && tick && !reload_q && (cnt_q == '0);
  assign baud     = baud_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= 1'b1;
      baud_q   <= 1'b0;
    end else if (!en) begin
      baud_q <= 1'b0;
    end else if (tick) begin
      if (reload_q) begin
        cnt_q    <= tc;
        reload_q <= 1'b0;
      end else if (cnt_q == '0) begin
        reload_q <= 1'b1;
        baud_q   <= ~baud_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4: output forced low and count frozen while disabled
  p_out_low_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !baud);
  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
  // R5: a reload takes whatever constant the byte registers held at that edge
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && reload_q) |=> (cnt_q == $past(tc)));
  // R2: the output moves on a zero crossing and at no other enabled edge
  p_toggle_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (baud != $past(baud)));
  p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zero_evt) |=> $stable(baud));

endmodule

// File: rtl/brg_post_div.sv
module brg_post_div
  import brg_pkg::*;
#(
  parameter int DIV_MAX = 64,
  localparam int DW     = $clog2(DIV_MAX)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      evt,
  input  samp_div_e div_code,
  output logic      samp
);

  logic [DW-1:0] ecnt_q;
  logic          samp_q;
  int unsigned   ratio;

  assign ratio = div_ratio(div_code);
  assign samp  = samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      samp_q <= 1'b0;
    end else if (!en) begin
      ecnt_q <= '0;
      samp_q <= 1'b0;
    end else if (evt) begin
      if (int'(ecnt_q) >= int'(ratio) - 1) begin
        ecnt_q <= '0;
        samp_q <= ~samp_q;
      end else begin
        ecnt_q <= ecnt_q + 1'b1;
      end
    end
  end

  // R10: sampling clock low while the generator is stopped
  p_samp_low_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !samp);
  // R9: the sampling clock only moves on a bit-clock zero crossing
  p_samp_moves_on_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !evt) |=> $stable(samp));

endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int TC_W    = 16,
  parameter int BYTE_W  = 8,
  parameter int DIV_MAX = 64,
  localparam int NB     = TC_W / BYTE_W,
  localparam int AW     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tc_wr_en,
  input  logic [AW-1:0]     tc_addr,
  input  logic [BYTE_W-1:0] tc_wr_data,
  input  logic [AW-1:0]     tc_rd_addr,
  output logic [BYTE_W-1:0] tc_rd_data,
  input  logic              brg_enable,
  input  logic              src_pclk,
  input  logic              ext_clk,
  input  logic [1:0]        samp_div,
  input  logic              zc_irq_en,
  input  logic              zc_ack,
  output logic              baud_clk,
  output logic              samp_clk,
  output logic              zc_status,
  output logic              zc_irq
);

  logic [TC_W-1:0] tc;
  logic            tick;
  logic            zero_evt;
  logic            status_q;
  logic            irq_q;

  brg_tc_regs #(.TC_W(TC_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(tc_wr_en), .wr_addr(tc_addr),
    .wr_data(tc_wr_data), .rd_addr(tc_rd_addr), .rd_data(tc_rd_data), .tc(tc)
  );

  brg_src_tick #(.SYNC_STAGES(2)) u_src (
    .clk(clk), .rst_n(rst_n), .src_pclk(src_pclk), .ext_pin(ext_clk), .tick(tick)
  );

  brg_counter #(.TC_W(TC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(brg_enable), .tick(tick), .tc(tc),
    .baud(baud_clk), .zero_evt(zero_evt)
  );

  brg_post_div #(.DIV_MAX(DIV_MAX)) u_pdiv (
    .clk(clk), .rst_n(rst_n), .en(brg_enable), .evt(zero_evt),
    .div_code(samp_div_e'(samp_div)), .samp(samp_clk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= zero_evt & zc_irq_en;
      if (zero_evt)    status_q <= 1'b1;
      else if (zc_ack) status_q <= 1'b0;
    end
  end

  assign zc_status = status_q;
  assign zc_irq    = irq_q;

  // R7: every crossing leaves the status bit set, even against an acknowledge
  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> zc_status);
  // R8: no interrupt pulse for a crossing while the enable is low
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !zc_irq_en) |=> !zc_irq);
  // R8: every pulse coincides with a bit-clock level change
  p_irq_with_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> (baud_clk != $past(baud_clk)));

endmodule

// File: tb/tb_brg_top.sv
module tb_brg_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tc_wr_en = 1'b0;
  logic [0:0] tc_addr = '0;
  logic [7:0] tc_wr_data = '0;
  logic [0:0] tc_rd_addr = '0;
  logic [7:0] tc_rd_data;
  logic       brg_enable = 1'b0;
  logic       src_pclk = 1'b1;
  logic       ext_clk = 1'b0;
  logic [1:0] samp_div = 2'b00;
  logic       zc_irq_en = 1'b0;
  logic       zc_ack = 1'b0;
  logic       baud_clk, samp_clk, zc_status, zc_irq;

  int checks = 0;
  int errors = 0;
  bit ext_run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brg_top dut (
    .clk(clk), .rst_n(rst_n), .tc_wr_en(tc_wr_en), .tc_addr(tc_addr),
    .tc_wr_data(tc_wr_data), .tc_rd_addr(tc_rd_addr), .tc_rd_data(tc_rd_data),
    .brg_enable(brg_enable), .src_pclk(src_pclk), .ext_clk(ext_clk),
    .samp_div(samp_div), .zc_irq_en(zc_irq_en), .zc_ack(zc_ack),
    .baud_clk(baud_clk), .samp_clk(samp_clk), .zc_status(zc_status), .zc_irq(zc_irq)
  );

  initial begin : ext_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph == 4) begin ph = 0; ext_clk = ~ext_clk; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input bit use_samp);
    return use_samp ? samp_clk : baud_clk;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; brg_enable = 1'b0; src_pclk = 1'b1; ext_run = 1'b0;
    samp_div = 2'b00; zc_irq_en = 1'b0; zc_ack = 1'b0; tc_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_tc(input int val);
    @(negedge clk);
    tc_wr_en = 1'b1; tc_addr = 1'b0; tc_wr_data = val[7:0];
    @(negedge clk);
    tc_addr = 1'b1; tc_wr_data = val[15:8];
    @(negedge clk);
    tc_wr_en = 1'b0;
  endtask

  // Waits for a rising edge of the chosen clock, then measures high and low spans.
  task automatic measure(input bit use_samp, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (sig(use_samp) !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (sig(use_samp) !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    while (sig(use_samp) === 1'b1 && guard < 20000) begin @(negedge clk); hi++; guard++; end
    while (sig(use_samp) === 1'b0 && guard < 20000) begin @(negedge clk); lo++; guard++; end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(baud_clk === 1'b0, "R2 reset baud_clk", baud_clk, 0);
    chk(samp_clk === 1'b0, "R10 reset samp_clk", samp_clk, 0);
    chk(zc_status === 1'b0, "R7 reset zc_status", zc_status, 0);
    tc_rd_addr = 1'b1; #1;
    chk(tc_rd_data === 8'h00, "R1 reset high byte", tc_rd_data, 0);
  endtask

  task automatic t_readback();
    do_reset();
    write_tc(16'hA53C);
    tc_rd_addr = 1'b0; #1;
    chk(tc_rd_data === 8'h3C, "R1 low byte", tc_rd_data, 8'h3C);
    tc_rd_addr = 1'b1; #1;
    chk(tc_rd_data === 8'hA5, "R1 high byte", tc_rd_data, 8'hA5);
  endtask

  task automatic t_period(input int tc);
    int hi, lo;
    do_reset();
    write_tc(tc);
    brg_enable = 1'b1;
    measure(1'b0, hi, lo);
    chk(hi == tc + 2, "R2 high span", hi, tc + 2);
    chk(lo == tc + 2, "R2 low span", lo, tc + 2);
  endtask

  task automatic t_first_edge();
    int n = 0;
    do_reset();
    write_tc(6);
    brg_enable = 1'b1;
    while (baud_clk !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n == 8, "R2 first rise edge count", n, 8);
  endtask

  task automatic t_formula();
    int f = 2400, bps = 100, tc, hi, lo;
    tc = (f + bps) / (2 * bps) - 2;
    do_reset();
    write_tc(tc);
    brg_enable = 1'b1;
    measure(1'b0, hi, lo);
    chk(hi + lo == f / bps, "R3 period from formula", hi + lo, f / bps);
  endtask

  task automatic t_pause_resume();
    int m = 0;
    bit bad = 1'b0;
    do_reset();
    write_tc(10);
    brg_enable = 1'b1;
    repeat (5) @(negedge clk);
    brg_enable = 1'b0;
    repeat (20) begin @(negedge clk); if (baud_clk !== 1'b0 || zc_status !== 1'b0) bad = 1'b1; end
    chk(!bad, "R4 quiet while disabled", bad, 0);
    brg_enable = 1'b1;
    while (baud_clk !== 1'b1 && m < 1000) begin @(negedge clk); m++; end
    chk(m == 7, "R4 resume count", m, 7);
    brg_enable = 1'b0;
    @(negedge clk);
    chk(baud_clk === 1'b0, "R4 low after disable", baud_clk, 0);
  endtask

  task automatic t_live_write();
    int hi = 0, lo = 0, g = 0;
    do_reset();
    write_tc(5);
    brg_enable = 1'b1;
    while (baud_clk !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
    tc_wr_en = 1'b1; tc_addr = 1'b0; tc_wr_data = 8'd9;
    while (baud_clk === 1'b1 && g < 2000) begin @(negedge clk); tc_wr_en = 1'b0; hi++; g++; end
    while (baud_clk === 1'b0 && g < 3000) begin @(negedge clk); lo++; g++; end
    chk(hi == 7, "R5 current half keeps old TC", hi, 7);
    chk(lo == 11, "R5 next half uses new TC", lo, 11);
  endtask

  task automatic t_ext_source();
    int hi, lo, moves = 0;
    do_reset();
    write_tc(0);
    src_pclk = 1'b0;
    brg_enable = 1'b1;
    repeat (100) begin @(negedge clk); if (baud_clk) moves++; end
    chk(moves == 0, "R6 static pin no progress", moves, 0);
    ext_run = 1'b1;
    measure(1'b0, hi, lo);
    chk(hi + lo == 32, "R6 period from pin edges", hi + lo, 32);
    src_pclk = 1'b1;
    write_tc(1);
    measure(1'b0, hi, lo);
    measure(1'b0, hi, lo);
    chk(hi + lo == 6, "R6 pin ignored on processor clock", hi + lo, 6);
    ext_run = 1'b0;
  endtask

  task automatic t_status();
    int g = 0;
    do_reset();
    write_tc(200);
    brg_enable = 1'b1;
    repeat (100) @(negedge clk);
    chk(zc_status === 1'b0, "R7 clear before crossing", zc_status, 0);
    while (baud_clk !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
    chk(zc_status === 1'b1, "R7 set by crossing", zc_status, 1);
    zc_ack = 1'b1;
    @(negedge clk);
    zc_ack = 1'b0;
    chk(zc_status === 1'b0, "R7 cleared by ack", zc_status, 0);
    zc_ack = 1'b1;
    while (baud_clk !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
    chk(zc_status === 1'b1, "R7 set wins over ack", zc_status, 1);
    @(negedge clk);
    chk(zc_status === 1'b0, "R7 ack clears after", zc_status, 0);
    zc_ack = 1'b0;
  endtask

  task automatic t_irq();
    int pulses = 0, mism = 0;
    logic prev;
    do_reset();
    write_tc(3);
    brg_enable = 1'b1;
    prev = baud_clk;
    repeat (200) begin
      @(negedge clk);
      if (zc_irq) pulses++;
      prev = baud_clk;
    end
    chk(pulses == 0, "R8 no pulse while irq disabled", pulses, 0);
    zc_irq_en = 1'b1;
    @(negedge clk);
    prev = baud_clk;
    repeat (200) begin
      @(negedge clk);
      if (zc_irq) pulses++;
      if (zc_irq !== (baud_clk !== prev)) mism++;
      prev = baud_clk;
    end
    chk(mism == 0, "R8 pulse on each toggle", mism, 0);
    chk(pulses == 40, "R8 pulse count", pulses, 40);
  endtask

  task automatic t_postdiv(input int code, input int ratio);
    int hi, lo;
    do_reset();
    write_tc(0);
    samp_div = code[1:0];
    brg_enable = 1'b1;
    measure(1'b1, hi, lo);
    chk(hi + lo == 4 * ratio, "R9 sampling period", hi + lo, 4 * ratio);
    chk(hi == lo, "R9 sampling duty", hi, lo);
  endtask

  task automatic t_samp_disable();
    int bad = 0;
    do_reset();
    write_tc(0);
    samp_div = 2'b01;
    brg_enable = 1'b1;
    while (samp_clk !== 1'b1 && bad < 1000) begin @(negedge clk); bad++; end
    brg_enable = 1'b0;
    bad = 0;
    repeat (50) begin @(negedge clk); if (samp_clk !== 1'b0) bad++; end
    chk(bad == 0, "R10 samp low while disabled", bad, 0);
    brg_enable = 1'b1;
    bad = 0;
    while (samp_clk !== 1'b1 && bad < 1000) begin @(negedge clk); bad++; end
    chk(bad == 32, "R10 divider restarts", bad, 32);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_reset_state();
    t_readback();
    t_period(0);
    t_period(3);
    t_period(300);
    t_first_edge();
    t_formula();
    t_pause_resume();
    t_live_write();
    t_ext_source();
    t_status();
    t_irq();
    t_postdiv(0, 1);
    t_postdiv(1, 16);
    t_postdiv(2, 32);
    t_postdiv(3, 64);
    t_samp_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule